// File: doc/BRIEF.md
# Successive-Approximation Conversion Cycle Sequencer

This block runs one conversion cycle of a 12-bit successive-approximation converter. It waits in idle until a convert request arrives. It then captures a length-select bit, raises a busy status and switches the sample/hold control to hold. It waits a fixed number of cycles so the held value can settle. After that it steps a trial code MSB first, and on each clock it keeps or clears the bit under test according to a single comparator bit. The trial runs either the full 12 bits or a short run of 8 bits.

When the last bit has been decided, the result is declared valid and the sample/hold control returns to sample. Status stays high for a fixed acquisition window, so the result is valid well before status falls. The analog comparator, the DAC and the sample-and-hold circuit are outside the block. The trial code output drives the DAC, and the comparator result is fed back on `cmp_i`. All delays are counted in clock cycles.

Top module: `sar_cycle_seq`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active high), the block goes to idle with `status_o`, `hold_o` and `valid_o` low and with `trial_o` and `result_o` all zero.
- R2: A clock edge that finds the block idle with `start_i` high begins a conversion: from the next cycle `status_o` and `hold_o` are both high and `valid_o` is low.
- R3: After a start, `trial_o` stays zero for `HOLD_CYC` cycles (hold settling). In the following cycle the first trial code shows only the MSB set (0x800).
- R4: Bits are tried MSB first, one per cycle. The bit under test is set in `trial_o` and is kept if `cmp_i` is 1 at the next edge, or cleared if it is 0. With `cmp_i` = (`trial_o` <= V), the full result equals V.
- R5: `short_i` low at start gives 12 bit trials. `short_i` high gives 8 trials (bits 11..4), and `result_o[3:0]` is zero.
- R6: The length select is captured at the start edge. Changes on `short_i` during a conversion have no effect on its length or result.
- R7: `start_i` is ignored while `status_o` is high. The status length and the result of the running conversion are unchanged, and no new conversion follows.
- R8: `hold_o` is high for `HOLD_CYC` + N cycles (N = 8 or 12). `valid_o` is then high with `hold_o` low for `ACQ_CYC` cycles before `status_o` falls, so status is high for `HOLD_CYC` + N + `ACQ_CYC` cycles.
- R9: `result_o` and `valid_o` hold their value after `status_o` falls, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Convert request, sampled at each edge |
| short_i | input | 1 | Length select: 0 = 12-bit, 1 = 8-bit |
| cmp_i | input | 1 | Comparator: 1 = input at or above trial code |
| status_o | output | 1 | Busy during the whole conversion cycle |
| hold_o | output | 1 | 1 = hold, 0 = sample |
| trial_o | output | RES_W (12) | Trial code for the DAC |
| result_o | output | RES_W (12) | Conversion result, zero while not valid |
| valid_o | output | 1 | Result is final |

## Verification
On every cycle, the assertions check that each decided bit follows the comparator value sampled one cycle earlier and that the register holds between trials. They also check that the latched length select stays frozen, that a start seen while busy never opens a new settling phase, that hold is low during acquisition, and that short results carry zero low bits. Only the bench scenarios can show the end-to-end numbers. These are the exact status, hold and valid lengths in cycles, the settling-phase trial code, and results for chosen analog values at both lengths. The bench also toggles the select bit and pulses start in the middle of a conversion, then checks that the outcome is unchanged and that the result persists after status falls.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_TRIAL  = 2'd2,
    PH_ACQ    = 2'd3
  } phase_t;

  // Number of bit decisions for the chosen length.
  function automatic int unsigned trial_count(input logic short_sel,
                                              input int unsigned full_w,
                                              input int unsigned short_w);
    return short_sel ? short_w : full_w;
  endfunction

  // Index of the last bit decided for the chosen length.
  function automatic int unsigned last_bit(input logic short_sel,
                                           input int unsigned full_w,
                                           input int unsigned short_w);
    return short_sel ? (full_w - short_w) : 0;
  endfunction

  // Total cycles that status stays high.
  function automatic int unsigned busy_cycles(input logic short_sel,
                                              input int unsigned full_w,
                                              input int unsigned short_w,
                                              input int unsigned settle_c,
                                              input int unsigned acq_c);
    return settle_c + trial_count(short_sel, full_w, short_w) + acq_c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sar_delay_timer.sv
module sar_delay_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = en && (cnt_q == (limit - ONE));

  always_ff @(posedge clk) begin
    if (rst || !en || expire) cnt_q <= '0;
    else                      cnt_q <= cnt_q + ONE;
  end

  // R8: the counter never runs past the window it times
  a_r8_count_in_window: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt_q < limit));

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int RES_W = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic             cmp_i,
  input  logic [IDX_W-1:0] last_idx,
  output logic [RES_W-1:0] trial_code,
  output logic [RES_W-1:0] sar_value,
  output logic             last_step
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(RES_W - 1);

  logic [RES_W-1:0] sar_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] probe;

  for (genvar b = 0; b < RES_W; b++) begin : g_probe
    assign probe[b] = step && (idx_q == IDX_W'(b));
  end

  assign trial_code = sar_q | probe;
  assign sar_value  = sar_q;
  assign last_step  = step && (idx_q == last_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      sar_q <= '0;
      idx_q <= TOP;
    end else if (load) begin
      sar_q <= '0;
      idx_q <= TOP;
    end else if (step) begin
      sar_q[idx_q] <= cmp_i;
      if (idx_q != '0) idx_q <= idx_q - ONE;
    end
  end

  // R4: the decided bit equals the comparator value seen at the trial
  a_r4_keep_bit: assert property (@(posedge clk) disable iff (rst)
    step |=> (sar_q[$past(idx_q)] == $past(cmp_i)));

  // R9: the register holds between trials and starts
  a_r9_hold_value: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(sar_q));

endmodule

// File: rtl/sar_cycle_fsm.sv
module sar_cycle_fsm
  import sar_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  input  logic   short_i,
  input  logic   timer_expire,
  input  logic   last_step,
  output phase_t phase,
  output logic   short_q,
  output logic   conv_begin,
  output logic   step,
  output logic   timer_en,
  output logic   in_acq,
  output logic   status,
  output logic   hold,
  output logic   done_q
);
  phase_t phase_q, phase_d;

  assign phase      = phase_q;
  assign conv_begin = (phase_q == PH_IDLE) && start_i;
  assign step       = (phase_q == PH_TRIAL);
  assign in_acq     = (phase_q == PH_ACQ);
  assign timer_en   = (phase_q == PH_SETTLE) || in_acq;
  assign status     = (phase_q != PH_IDLE);
  assign hold       = (phase_q == PH_SETTLE) || step;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (conv_begin)   phase_d = PH_SETTLE;
      PH_SETTLE: if (timer_expire) phase_d = PH_TRIAL;
      PH_TRIAL:  if (last_step)    phase_d = PH_ACQ;
      PH_ACQ:    if (timer_expire) phase_d = PH_IDLE;
      default:                     phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      short_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (conv_begin) begin
        short_q <= short_i;
        done_q  <= 1'b0;
      end else if (step && last_step) begin
        done_q  <= 1'b1;
      end
    end
  end

  // R2: an accepted start raises status and hold next cycle
  a_r2_start_raises: assert property (@(posedge clk) disable iff (rst)
    conv_begin |=> (status && hold && !done_q));

  // R3: settling is left only when the timer expires
  a_r3_settle_wait: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_SETTLE) && !timer_expire) |=> (phase_q == PH_SETTLE));

  // R6: latched length select is frozen during a conversion
  a_r6_len_held: assert property (@(posedge clk) disable iff (rst)
    (status && $past(status)) |-> $stable(short_q));

  // R7: a start while busy never opens a new settling phase
  a_r7_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    (status && start_i) |=> ((phase_q != PH_SETTLE) || $past(phase_q == PH_SETTLE)));

endmodule

// File: rtl/sar_cycle_seq.sv
module sar_cycle_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_W    = 12,
  parameter int SHORT_W  = 8,
  parameter int HOLD_CYC = 10,
  parameter int ACQ_CYC  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             short_i,
  input  logic             cmp_i,
  output logic             status_o,
  output logic             hold_o,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o
);
  localparam int IDX_W = $clog2(RES_W);
  localparam int CNT_W = $clog2(max2(HOLD_CYC, ACQ_CYC) + 1);
  localparam int LOW_W = RES_W - SHORT_W;
  localparam logic [CNT_W-1:0] HOLD_L = CNT_W'(HOLD_CYC);
  localparam logic [CNT_W-1:0] ACQ_L  = CNT_W'(ACQ_CYC);
  localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(last_bit(1'b0, RES_W, SHORT_W));
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(last_bit(1'b1, RES_W, SHORT_W));

  phase_t           phase;
  logic             short_q, conv_begin, step, timer_en, in_acq;
  logic             timer_expire, last_step, done_q;
  logic [CNT_W-1:0] timer_limit;
  logic [IDX_W-1:0] last_idx;
  logic [RES_W-1:0] sar_value;

  assign timer_limit = in_acq ? ACQ_L : HOLD_L;
  assign last_idx    = short_q ? LAST_SHORT : LAST_FULL;

  sar_cycle_fsm u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .short_i(short_i),
    .timer_expire(timer_expire), .last_step(last_step),
    .phase(phase), .short_q(short_q), .conv_begin(conv_begin), .step(step),
    .timer_en(timer_en), .in_acq(in_acq), .status(status_o), .hold(hold_o),
    .done_q(done_q)
  );

  sar_delay_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .en(timer_en), .limit(timer_limit), .expire(timer_expire)
  );

  sar_bit_engine #(.RES_W(RES_W), .IDX_W(IDX_W)) u_engine (
    .clk(clk), .rst(rst), .load(conv_begin), .step(step), .cmp_i(cmp_i),
    .last_idx(last_idx), .trial_code(trial_o), .sar_value(sar_value),
    .last_step(last_step)
  );

  assign valid_o  = done_q;
  assign result_o = done_q ? sar_value : '0;

  // R8: during acquisition the sample/hold is back in sample
  a_r8_acq_sampling: assert property (@(posedge clk) disable iff (rst)
    (valid_o && status_o) |-> !hold_o);

  // R5: short results carry zero low bits
  a_r5_short_low_zero: assert property (@(posedge clk) disable iff (rst)
    (valid_o && short_q) |-> (result_o[LOW_W-1:0] == '0));

endmodule

// File: tb/sar_cycle_seq_test.sv
module sar_cycle_seq_test;
  localparam int H = 10;
  localparam int A = 10;

  logic clk = 1'b0, rst = 1'b1, start_i = 1'b0, short_i = 1'b0;
  logic cmp_i, status_o, hold_o, valid_o;
  logic [11:0] trial_o, result_o;
  logic [11:0] target = '0;

  int n_checks = 0, n_fail = 0;

  typedef struct { logic [11:0] res; int nb; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  assign cmp_i = (trial_o <= target);

  sar_cycle_seq #(.RES_W(12), .SHORT_W(8), .HOLD_CYC(H), .ACQ_CYC(A)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .short_i(short_i), .cmp_i(cmp_i),
    .status_o(status_o), .hold_o(hold_o), .trial_o(trial_o),
    .result_o(result_o), .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  bit in_conv = 0;
  int c_n = 0, hold_n = 0, valid_n = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (status_o) begin
        if (!in_conv) begin
          in_conv = 1; c_n = 0; hold_n = 0; valid_n = 0;
        end
        c_n++;
        if (hold_o) hold_n++;
        if (valid_o) valid_n++;
        if (c_n == H) chk(trial_o == 12'h000, "R3", "settle trial code", trial_o, 0);
        if (c_n == H + 1) chk(trial_o == 12'h800, "R3", "first trial code", trial_o, 12'h800);
      end else if (in_conv) begin
        exp_t e;
        in_conv = 0;
        if (q.size() == 0) begin
          chk(1'b0, "R7", "unexpected conversion", 1, 0);
        end else begin
          e = q.pop_front();
          chk(c_n == H + e.nb + A, "R8", "status length", c_n, H + e.nb + A);
          chk(hold_n == H + e.nb, "R8", "hold length", hold_n, H + e.nb);
          chk(valid_n == A, "R8", "valid lead before status low", valid_n, A);
          chk(result_o == e.res, "R4", "result", result_o, e.res);
          chk(valid_o == 1'b1, "R9", "valid after status low", valid_o, 1);
        end
      end
    end
  end

  // driver: one conversion, optional disturbances mid-run
  task automatic run_conv(input logic [11:0] v, input bit shrt, input bit disturb);
    exp_t e;
    target = v;
    e.nb  = shrt ? 8 : 12;
    e.res = shrt ? (v & 12'hFF0) : v;
    q.push_back(e);
    @(negedge clk);
    start_i = 1'b1; short_i = shrt;
    @(negedge clk);
    start_i = 1'b0;
    chk(status_o && hold_o && !valid_o, "R2", "status/hold after start",
        {status_o, hold_o, valid_o}, 3'b110);
    if (disturb) begin
      repeat (3) @(negedge clk);
      short_i = ~shrt;             // R6: must not matter
      start_i = 1'b1;              // R7: must be ignored
      @(negedge clk);
      start_i = 1'b0;
      repeat (H + 4) @(negedge clk);
      start_i = 1'b1;              // R7: start during trials
      @(negedge clk);
      start_i = 1'b0;
    end
    while (status_o) @(negedge clk);
    short_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!status_o, "R7", "no conversion after ignored start", status_o, 0);
    chk(result_o == e.res && valid_o, "R9", "result held in idle", result_o, e.res);
    if (shrt) chk(result_o[3:0] == 4'h0, "R5", "short low bits", result_o[3:0], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!status_o && !hold_o && !valid_o && trial_o == 0 && result_o == 0,
        "R1", "reset state", {status_o, hold_o, valid_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!status_o && !valid_o, "R1", "idle after reset", status_o, 0);

    run_conv(12'hA5C, 1'b0, 1'b0);   // R4 full
    run_conv(12'hA5C, 1'b1, 1'b0);   // R5 short
    run_conv(12'h000, 1'b0, 1'b0);
    run_conv(12'hFFF, 1'b0, 1'b0);
    run_conv(12'hFFF, 1'b1, 1'b0);
    run_conv(12'h801, 1'b0, 1'b1);   // R6/R7 full, select flipped to short
    run_conv(12'h123, 1'b1, 1'b1);   // R6/R7 short, select flipped to full

    // reset mid-conversion returns to idle
    q.push_back('{res: 12'h000, nb: 0});
    @(negedge clk); start_i = 1'b1; target = 12'h555;
    @(negedge clk); start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1; void'(q.pop_back());
    @(negedge clk); in_conv = 0;
    chk(!status_o && !hold_o && !valid_o && result_o == 0, "R1", "reset mid-run",
        {status_o, hold_o, valid_o}, 0);
    rst = 1'b0;
    run_conv(12'h555, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule